// File: doc/BRIEF.md
# Dual-Pointer Shared Sector Buffer

This block holds one 512-byte sector buffer that two agents share: a host processor, which sees the buffer through a single data register, and a disk-side controller, which moves one byte per strobe between the buffer and the media. Each side has its own hidden 9-bit pointer. The pointer advances after every access and wraps modulo 512. Neither pointer can be read or loaded. The only way to set them is a pointer-clear request, which returns both to zero.

Three status flags let software stay in step with the disk side:
- a last-accessor flag (`stat_drq`), high when the disk side touched the buffer last;
- a coincidence flag (`stat_eq`), recomputed only when the host pointer moves;
- a sticky overrun flag (`stat_lost`).

Because the coincidence flag ignores disk-side movement, a buffer the disk has just filled completely does not look empty to the host. A half-swap input flips the top address bit of the host's effective address, so the host sees the other 256-byte half.

Both data ports are valid-only streams. The block accepts every beat in the cycle it is offered and never applies back-pressure, so there is no ready signal. Read data returns one cycle after the strobe, together with its own valid pulse.

Top module: `sector_xfer_buffer`

## Requirements
- R1: After reset, `stat_drq`, `stat_eq` and `stat_lost` are 0, and both pointers are 0.
- R2: A host beat (`cpu_valid`=1, `ptr_clr`=0) accesses the byte at the host effective address: `cpu_we`=1 stores `cpu_wdata`, and `cpu_we`=0 returns the byte on `cpu_rdata`, with `cpu_rvalid`=1 in the next cycle. The host pointer then advances by one and wraps from 511 to 0.
- R3: A host beat clears `stat_drq`. A disk beat sets `stat_drq`. If both beats arrive in the same cycle, `stat_drq` ends up 1.
- R4: On a host beat, `stat_eq` becomes 1 when the advanced host pointer equals the disk pointer (including any disk advance in that same cycle), and 0 otherwise. In cycles without a host beat, `stat_eq` holds its value.
- R5: A host beat that starts while `stat_eq`=1 sets `stat_lost`. `stat_lost` stays 1 until `ptr_clr` or reset.
- R6: A disk beat (`dsk_valid`=1, `ptr_clr`=0) uses the disk pointer. With `dsk_dir`=1, `dsk_wdata` is stored. With `dsk_dir`=0, the byte returns on `dsk_rdata` with `dsk_rvalid`=1 in the next cycle. The disk pointer then advances by one and wraps modulo 512.
- R7: `ptr_clr`=1 zeroes both pointers and clears `stat_eq` and `stat_lost`. It leaves `stat_drq` unchanged. Any beat offered in the same cycle is dropped.
- R8: With `half_swap`=1, bit 8 of the host effective address is inverted. The host pointer itself, and the `stat_eq` comparison, use the unswapped pointer.
- R9: No access is ever refused. A host read while `stat_eq`=1 returns whatever byte is stored at that position.
- R10: When host and disk both write the same address in one cycle, the disk byte is kept. A read in the same cycle as a write to its address returns the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Host beat strobe |
| cpu_we | input | 1 | Host beat is a write |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rvalid | output | 1 | Host read byte valid |
| cpu_rdata | output | 8 | Host read byte |
| dsk_valid | input | 1 | Disk beat strobe |
| dsk_dir | input | 1 | 1 = disk fills buffer, 0 = disk drains buffer |
| dsk_wdata | input | 8 | Disk byte into buffer |
| dsk_rvalid | output | 1 | Disk read byte valid |
| dsk_rdata | output | 8 | Disk byte out of buffer |
| ptr_clr | input | 1 | Zero both pointers |
| half_swap | input | 1 | Invert bit 8 of the host address |
| stat_drq | output | 1 | Disk side accessed last |
| stat_eq | output | 1 | Pointers coincided at the last host beat |
| stat_lost | output | 1 | Sticky host overrun |

## Verification
The hardest case to reach from the ports is the full-versus-empty ambiguity. The disk side must run a whole 512-byte lap, so its pointer wraps back onto the host pointer, while `stat_eq` stays low. Then the host must drain exactly 512 bytes, so that only the last beat raises `stat_eq`, and one further beat must raise `stat_lost` and return a stale byte. Directed sequences build those laps after a pointer clear and also cover swapped-half reads and colliding writes. A long seeded random run then mixes both ports, occasional clears and swaps, and compares every flag and read byte against a bench model.

// File: rtl/sxb_pkg.sv
`timescale 1ns/1ps
package sxb_pkg;
  typedef enum logic {
    DSK_DRAIN = 1'b0,
    DSK_FILL  = 1'b1
  } dsk_dir_e;

  typedef struct packed {
    logic drq;
    logic eq;
    logic lost;
  } sxb_flags_t;
endpackage

// File: rtl/sxb_ptr.sv
`timescale 1ns/1ps
module sxb_ptr #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_nxt
);
  // next value is exported so the flag logic can compare post-advance pointers
  always_comb begin
    if (clr)      ptr_nxt = '0;
    else if (adv) ptr_nxt = ptr + AW'(1);
    else          ptr_nxt = ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end
endmodule

// File: rtl/sxb_store.sv
`timescale 1ns/1ps
module sxb_store #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // port b (disk) is written last, so it wins a same-address collision;
  // reads return the content present before this edge
  always_ff @(posedge clk) begin
    if (a_en && a_we)  mem[a_addr] <= a_wdata;
    if (b_en && b_we)  mem[b_addr] <= b_wdata;
    if (a_en && !a_we) a_rdata <= mem[a_addr];
    if (b_en && !b_we) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/sxb_flags.sv
`timescale 1ns/1ps
module sxb_flags
  import sxb_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cpu_go,
  input  logic          dsk_go,
  input  logic [AW-1:0] cpu_ptr_nxt,
  input  logic [AW-1:0] dsk_ptr_nxt,
  output sxb_flags_t    flags
);
  sxb_flags_t nxt;

  always_comb begin
    nxt = flags;
    if (clr) begin
      nxt.eq   = 1'b0;
      nxt.lost = 1'b0;
    end else begin
      // disk assignment comes second: a shared cycle counts as disk-last
      if (cpu_go) nxt.drq = 1'b0;
      if (dsk_go) nxt.drq = 1'b1;
      if (cpu_go) begin
        if (flags.eq) nxt.lost = 1'b1;
        nxt.eq = (cpu_ptr_nxt == dsk_ptr_nxt);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end
endmodule

// File: rtl/sector_xfer_buffer.sv
`timescale 1ns/1ps
module sector_xfer_buffer
  import sxb_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dsk_valid,
  input  logic              dsk_dir,
  input  logic [DATA_W-1:0] dsk_wdata,
  output logic              dsk_rvalid,
  output logic [DATA_W-1:0] dsk_rdata,
  input  logic              ptr_clr,
  input  logic              half_swap,
  output logic              stat_drq,
  output logic              stat_eq,
  output logic              stat_lost
);
  localparam int SWAP_BIT = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] SWAP_MASK = ADDR_W'(1) << SWAP_BIT;

  logic              cpu_go, dsk_go, dsk_fill;
  logic [ADDR_W-1:0] cpu_ptr, cpu_ptr_nxt, dsk_ptr, dsk_ptr_nxt, cpu_addr;
  sxb_flags_t        flags;

  // a pointer clear in the same cycle drops both beats
  assign cpu_go   = cpu_valid && !ptr_clr;
  assign dsk_go   = dsk_valid && !ptr_clr;
  assign dsk_fill = (dsk_dir_e'(dsk_dir) == DSK_FILL);
  assign cpu_addr = half_swap ? (cpu_ptr ^ SWAP_MASK) : cpu_ptr;

  sxb_ptr #(.AW(ADDR_W)) u_cpu_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .adv(cpu_go),
    .ptr(cpu_ptr), .ptr_nxt(cpu_ptr_nxt)
  );

  sxb_ptr #(.AW(ADDR_W)) u_dsk_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .adv(dsk_go),
    .ptr(dsk_ptr), .ptr_nxt(dsk_ptr_nxt)
  );

  sxb_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk),
    .a_en(cpu_go), .a_we(cpu_we), .a_addr(cpu_addr),
    .a_wdata(cpu_wdata), .a_rdata(cpu_rdata),
    .b_en(dsk_go), .b_we(dsk_fill), .b_addr(dsk_ptr),
    .b_wdata(dsk_wdata), .b_rdata(dsk_rdata)
  );

  sxb_flags #(.AW(ADDR_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr),
    .cpu_go(cpu_go), .dsk_go(dsk_go),
    .cpu_ptr_nxt(cpu_ptr_nxt), .dsk_ptr_nxt(dsk_ptr_nxt),
    .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      dsk_rvalid <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_go && !cpu_we;
      dsk_rvalid <= dsk_go && !dsk_fill;
    end
  end

  assign stat_drq  = flags.drq;
  assign stat_eq   = flags.eq;
  assign stat_lost = flags.lost;
endmodule

// File: rtl/sxb_checker.sv
`timescale 1ns/1ps
module sxb_checker #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_valid,
  input logic          cpu_we,
  input logic          dsk_valid,
  input logic          ptr_clr,
  input logic          cpu_rvalid,
  input logic          stat_drq,
  input logic          stat_eq,
  input logic          stat_lost,
  input logic [AW-1:0] cpu_ptr,
  input logic [AW-1:0] dsk_ptr
);
  assert_cpu_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !ptr_clr) |=> (cpu_ptr == AW'($past(cpu_ptr) + AW'(1))));

  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_we && !ptr_clr) |=> cpu_rvalid);

  assert_drq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !dsk_valid && !ptr_clr) |=> !stat_drq);

  assert_drq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dsk_valid && !ptr_clr) |=> stat_drq);

  assert_eq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_valid && !ptr_clr) |=> $stable(stat_eq));

  assert_eq_eval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !ptr_clr) |=> (stat_eq == (cpu_ptr == dsk_ptr)));

  assert_lost_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !ptr_clr && stat_eq) |=> stat_lost);

  assert_lost_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_lost && !ptr_clr) |=> stat_lost);

  assert_ptr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (cpu_ptr == '0 && dsk_ptr == '0 && !stat_eq && !stat_lost));
endmodule

bind sector_xfer_buffer sxb_checker #(.AW(ADDR_W)) u_sxb_checker (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
  .dsk_valid(dsk_valid), .ptr_clr(ptr_clr), .cpu_rvalid(cpu_rvalid),
  .stat_drq(stat_drq), .stat_eq(stat_eq), .stat_lost(stat_lost),
  .cpu_ptr(cpu_ptr), .dsk_ptr(dsk_ptr)
);

// File: tb/tb_sector_xfer_buffer.sv
`timescale 1ns/1ps
module tb_sector_xfer_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_valid = 0, cpu_we = 0, dsk_valid = 0, dsk_dir = 0;
  logic       ptr_clr = 0, half_swap = 0;
  logic [7:0] cpu_wdata = 0, dsk_wdata = 0;
  logic       cpu_rvalid, dsk_rvalid, stat_drq, stat_eq, stat_lost;
  logic [7:0] cpu_rdata, dsk_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_mem [512];
  logic [8:0] m_cp, m_dp;
  logic       m_drq, m_eq, m_lost;

  always #2 clk = ~clk;

  sector_xfer_buffer dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .dsk_valid(dsk_valid), .dsk_dir(dsk_dir), .dsk_wdata(dsk_wdata),
    .dsk_rvalid(dsk_rvalid), .dsk_rdata(dsk_rdata), .ptr_clr(ptr_clr),
    .half_swap(half_swap), .stat_drq(stat_drq), .stat_eq(stat_eq),
    .stat_lost(stat_lost)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] nxt_ptr(input logic [8:0] p);
    return p + 9'd1;
  endfunction

  // one clock: drive, predict from the requirements, check after the edge
  task automatic beat(input logic cv, input logic cwe, input logic [7:0] cwd,
                      input logic dv, input logic ddir, input logic [7:0] dwd,
                      input logic clr, input logic swp);
    logic       cg, dg, e_crv, e_drv;
    logic [7:0] e_crd, e_drd;
    logic [8:0] ca, cpn, dpn;
    cpu_valid = cv; cpu_we = cwe; cpu_wdata = cwd;
    dsk_valid = dv; dsk_dir = ddir; dsk_wdata = dwd;
    ptr_clr = clr; half_swap = swp;
    cg = cv && !clr;              // R7: beats dropped under clear
    dg = dv && !clr;
    ca = m_cp ^ {swp, 8'h00};     // R8: swapped half
    e_crv = cg && !cwe;
    e_drv = dg && !ddir;
    e_crd = m_mem[ca];            // R10: old byte on collision
    e_drd = m_mem[m_dp];
    if (cg && cwe) m_mem[ca] = cwd;
    if (dg && ddir) m_mem[m_dp] = dwd; // R10: disk wins
    cpn = clr ? 9'd0 : (cg ? nxt_ptr(m_cp) : m_cp);
    dpn = clr ? 9'd0 : (dg ? nxt_ptr(m_dp) : m_dp);
    if (clr) begin
      m_eq = 0; m_lost = 0;
    end else begin
      if (cg) m_drq = 0;
      if (dg) m_drq = 1;
      if (cg) begin
        if (m_eq) m_lost = 1;
        m_eq = (cpn == dpn);
      end
    end
    m_cp = cpn; m_dp = dpn;
    @(posedge clk);
    #1;
    chk("R2 cpu_rvalid", {8'h0, cpu_rvalid}, {8'h0, e_crv});
    if (e_crv) chk("R2/R8/R9 cpu_rdata", {1'b0, cpu_rdata}, {1'b0, e_crd});
    chk("R6 dsk_rvalid", {8'h0, dsk_rvalid}, {8'h0, e_drv});
    if (e_drv) chk("R6 dsk_rdata", {1'b0, dsk_rdata}, {1'b0, e_drd});
    chk("R3 stat_drq", {8'h0, stat_drq}, {8'h0, m_drq});
    chk("R4 stat_eq", {8'h0, stat_eq}, {8'h0, m_eq});
    chk("R5 stat_lost", {8'h0, stat_lost}, {8'h0, m_lost});
  endtask

  task automatic idle();
    beat(0, 0, 8'h00, 0, 0, 8'h00, 0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_cp = 0; m_dp = 0; m_drq = 0; m_eq = 0; m_lost = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk("R1 stat_drq", {8'h0, stat_drq}, 9'd0);
    chk("R1 stat_eq", {8'h0, stat_eq}, 9'd0);
    chk("R1 stat_lost", {8'h0, stat_lost}, 9'd0);

    // R6/R4: disk fills one full lap; EQ must stay low
    for (int i = 0; i < 512; i++) beat(0, 0, 8'h00, 1, 1, 8'(i ^ 8'h5A), 0, 0);
    chk("R4 eq low after disk lap", {8'h0, stat_eq}, 9'd0);
    // R2/R4: host drains 512; only the last beat raises EQ
    for (int i = 0; i < 512; i++) beat(1, 0, 8'h00, 0, 0, 8'h00, 0, 0);
    chk("R4 eq high after host lap", {8'h0, stat_eq}, 9'd1);
    // R5/R9: one more read, stale byte at 0, LOST set and sticky
    beat(1, 0, 8'h00, 0, 0, 8'h00, 0, 0);
    chk("R9 stale byte", {1'b0, cpu_rdata}, {1'b0, 8'h5A});
    idle();
    chk("R5 lost sticky", {8'h0, stat_lost}, 9'd1);

    // R7: clear with both beats offered; nothing stored, DRQ held
    beat(1, 1, 8'hEE, 1, 1, 8'hDD, 1, 0);
    chk("R7 lost cleared", {8'h0, stat_lost}, 9'd0);
    beat(1, 0, 8'h00, 0, 0, 8'h00, 0, 0);
    chk("R7 write dropped", {1'b0, cpu_rdata}, {1'b0, 8'h5A});

    // R8: swapped read at pointer 0 reaches byte 256
    beat(0, 0, 8'h00, 0, 0, 8'h00, 1, 0);
    beat(1, 0, 8'h00, 0, 0, 8'h00, 0, 1);
    chk("R8 swapped byte", {1'b0, cpu_rdata}, {1'b0, 8'(9'd256 ^ 9'h5A)});

    // R10: colliding writes at address 0, disk byte kept
    beat(0, 0, 8'h00, 0, 0, 8'h00, 1, 0);
    beat(1, 1, 8'h11, 1, 1, 8'h22, 0, 0);
    chk("R3 drq on shared cycle", {8'h0, stat_drq}, 9'd1);
    beat(0, 0, 8'h00, 0, 0, 8'h00, 1, 0);
    beat(1, 0, 8'h00, 0, 0, 8'h00, 0, 0);
    chk("R10 disk wins", {1'b0, cpu_rdata}, {1'b0, 8'h22});

    // seeded random mix across all inputs
    for (int i = 0; i < 3000; i++) begin
      beat(($urandom % 3) != 0, $urandom % 2, 8'($urandom),
           ($urandom % 2) == 1, $urandom % 2, 8'($urandom),
           ($urandom % 97) == 0, ($urandom % 8) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule